// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two 16-bit two's complement numbers and returns their full 32-bit product. It has one adder/subtractor and no multiplier array. It does one iteration per clock. Each iteration looks at the lowest remaining bit of the multiplier operand. When that bit is set, the multiplicand is added into an upper accumulator. The upper accumulator then shifts right by one, and the bit it drops moves into a lower register. The lower register starts out holding the multiplier and gradually fills with the low half of the product. On the final iteration the multiplicand is subtracted instead of added, because the multiplier's top bit has negative weight. The upper accumulator is kept one bit wider than the operands, so every intermediate sum is exact and the correct sign is shifted in, even for the most negative operands.

A caller holds the operands steady and raises `start` for one cycle while the block is idle. Sixteen clocks later `done` pulses for one cycle, and `product` holds the exact result. A second output, `q15`, gives the fractional view: the product shifted left by one with the upper 16 bits kept, truncated. Both outputs stay unchanged until the next accepted start.

The control pins are plain: there is no ready signal and no back-pressure. A start that arrives while the block is busy is dropped, not queued. The result is valid in the `done` cycle and is lost as soon as a new start is accepted. A caller that starts a new operation in the `done` cycle must take the result in that same cycle.

Top module: `smul_seq`

## Requirements
- R1: When `done` is high, `product` equals the exact 32-bit two's complement product of the operands captured at the accepting start. This holds for every operand pair, including -32768 x -32768 (0x40000000) and either operand zero.
- R2: A start is accepted when `start` is high at a rising edge while `busy` is low. `done` then rises at the 16th rising edge after the accepting edge.
- R3: `busy` is high from the edge after acceptance until the edge that raises `done`. `done` lasts exactly one cycle, and `busy` is low while `done` is high.
- R4: A start that arrives while `busy` is high has no effect. Operand changes during a run also have no effect: the result, the `done` timing and the number of `done` pulses are unchanged.
- R5: `q15` equals `product` bits 30 down to 15. For -32768 x -32768 this gives 0x8000.
- R6: While the block is idle and no start is accepted, `product` and `q15` hold their values.
- R7: After reset, `busy` and `done` are low and `product` and `q15` are zero.
- R8: A start applied in the same cycle as `done` is accepted. It produces its own correct result 16 edges later, and the earlier result is still delivered in its `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply; honoured only while idle |
| multiplicand | input | 16 | Signed multiplicand, captured at acceptance |
| multiplier | input | 16 | Signed multiplier, captured at acceptance |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse; result valid |
| product | output | 32 | Signed 32-bit product |
| q15 | output | 16 | Product shifted left by one, upper half, truncated |

## Verification
Two functions can fall in the same cycle: the delivery of a finished result (`done`) and the acceptance of the next start. The bench provokes this by raising `start` with fresh operands in exactly the cycle where `done` is seen. It then checks that the finishing result is still correct in that cycle, and that the new operation finishes 16 edges later with its own correct product. Starts issued mid-run with different operands are used to show that a busy block discards them: the bench checks that no extra `done` pulse appears and that the result is unaffected.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    SM_IDLE = 1'b0,
    SM_RUN  = 1'b1
  } smul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last_step,
  output logic busy,
  output logic done
);
  import smul_pkg::*;

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  smul_state_e    state;
  logic [CW-1:0]  iter;

  assign load      = (state == SM_IDLE) && start;
  assign step      = (state == SM_RUN);
  assign last_step = step && (iter == LAST);
  assign busy      = step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SM_IDLE;
      iter  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SM_IDLE: begin
          if (start) begin
            state <= SM_RUN;
            iter  <= '0;
          end
        end
        SM_RUN: begin
          if (iter == LAST) begin
            state <= SM_IDLE;
            done  <= 1'b1;
          end else begin
            iter <= iter + CW'(1);
          end
        end
        default: state <= SM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smul_path.sv
module smul_path #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic           last_step,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] mcand;
  logic [W-1:0] acc_hi;
  logic [W-1:0] acc_lo;
  logic [W:0]   ext_a;
  logic [W:0]   ext_hi;
  logic [W:0]   sum;

  assign ext_a  = {mcand[W-1], mcand};
  assign ext_hi = {acc_hi[W-1], acc_hi};

  always_comb begin
    if (!acc_lo[0]) begin
      sum = ext_hi;
    end else if (last_step) begin
      sum = ext_hi - ext_a;
    end else begin
      sum = ext_hi + ext_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand  <= '0;
      acc_hi <= '0;
      acc_lo <= '0;
    end else if (load) begin
      mcand  <= op_a;
      acc_hi <= '0;
      acc_lo <= op_b;
    end else if (step) begin
      acc_hi <= sum[W:1];
      acc_lo <= {sum[0], acc_lo[W-1:1]};
    end
  end

  assign prod = {acc_hi, acc_lo};
endmodule

// File: rtl/smul_fmt.sv
module smul_fmt #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] prod,
  output logic [W-1:0]   frac
);
  assign frac = prod[2*W-2:W-1];
endmodule

// File: rtl/smul_seq.sv
module smul_seq #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product,
  output logic [W-1:0]   q15
);
  logic load;
  logic step;
  logic last_step;

  smul_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load      (load),
    .step      (step),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  smul_path #(.W(W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .last_step (last_step),
    .op_a      (multiplicand),
    .op_b      (multiplier),
    .prod      (product)
  );

  smul_fmt #(.W(W)) u_fmt (
    .prod (product),
    .frac (q15)
  );
endmodule

// File: rtl/smul_seq_chk.sv
module smul_seq_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   multiplicand,
  input logic [W-1:0]   multiplier,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product,
  input logic [W-1:0]   q15
);
  localparam int KW = $clog2(W) + 2;

  logic [W-1:0]          cap_a;
  logic [W-1:0]          cap_b;
  logic [KW-1:0]         runs;
  logic signed [2*W-1:0] ext_a;
  logic signed [2*W-1:0] ext_b;
  logic signed [2*W-1:0] ref_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
      runs  <= '0;
    end else if (start && !busy) begin
      cap_a <= multiplicand;
      cap_b <= multiplier;
      runs  <= '0;
    end else if (busy) begin
      runs <= runs + KW'(1);
    end
  end

  assign ext_a = {{W{cap_a[W-1]}}, cap_a};
  assign ext_b = {{W{cap_b[W-1]}}, cap_b};
  assign ref_p = ext_a * ext_b;

  // R1
  a_r1_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == ref_p));

  // R2
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (runs == KW'(W)));

  // R3
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  a_r4_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (runs != KW'(W - 1))) |=> (busy && !done));

  // R6
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(product) && $stable(q15)));
endmodule

bind smul_seq smul_seq_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .busy         (busy),
  .done         (done),
  .product      (product),
  .q15          (q15)
);

// File: tb/smul_seq_tb.sv
module smul_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] mcand = '0;
  logic [15:0] mplier = '0;
  logic        busy;
  logic        done;
  logic [31:0] product;
  logic [15:0] q15;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] exp_q[$];
  int          cyc_q[$];
  logic [31:0] last_exp = '0;

  smul_seq #(.W(16)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (mcand),
    .multiplier   (mplier),
    .busy         (busy),
    .done         (done),
    .product      (product),
    .q15          (q15)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] ea;
    logic signed [31:0] eb;
    ea = {{16{a[15]}}, a};
    eb = {{16{b[15]}}, b};
    return ea * eb;
  endfunction

  // called at a negedge; applies start for one cycle
  task automatic launch(input logic [15:0] a, input logic [15:0] b);
    mcand  = a;
    mplier = b;
    start  = 1'b1;
    last_exp = ref_mul(a, b);
    exp_q.push_back(last_exp);
    cyc_q.push_back(cyc + 17);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic issue(input logic [15:0] a, input logic [15:0] b);
    while (busy) @(negedge clk);
    launch(a, b);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected done pulse", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        int          ec;
        e  = exp_q.pop_front();
        ec = cyc_q.pop_front();
        check(product == e, "R1 product", product, e);
        check(q15 == e[30:15], "R5 q15", {16'd0, q15}, {16'd0, e[30:15]});
        check(cyc == ec, "R2 done timing", cyc, ec);
        check(!busy, "R3 busy low with done", {31'd0, busy}, 32'd0);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<150000 cycles", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7
    check(!busy && !done, "R7 control after reset", {30'd0, busy, done}, 32'd0);
    check(product == 32'd0 && q15 == 16'd0, "R7 outputs after reset", product, 32'd0);

    // R1 corner pairs
    issue(16'h0000, 16'h0000);
    issue(16'h0000, 16'h8000);
    issue(16'h8000, 16'h0000);
    issue(16'h8000, 16'h8000);
    issue(16'h7FFF, 16'h7FFF);
    issue(16'h8000, 16'h7FFF);
    issue(16'h7FFF, 16'h8000);
    issue(16'hFFFF, 16'hFFFF);
    issue(16'h0001, 16'hFFFF);
    issue(16'hFFFF, 16'h8000);
    issue(16'h3039, 16'h0000);
    issue(16'h0000, 16'hFFFF);
    issue(16'h4000, 16'h4000);
    drain();

    // R6: outputs hold while idle
    begin
      logic [31:0] held;
      held = product;
      repeat (6) @(negedge clk);
      check(product == held && product == last_exp, "R6 product held", product, last_exp);
      check(q15 == last_exp[30:15], "R6 q15 held", {16'd0, q15}, {16'd0, last_exp[30:15]});
    end

    // R4: start and operand changes during a run are ignored
    issue(16'h1234, 16'hFEDC);
    @(negedge clk);
    check(busy == 1'b1, "R3 busy during run", {31'd0, busy}, 32'd1);
    mcand  = 16'h7777;
    mplier = 16'h8001;
    start  = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    drain();
    repeat (20) @(negedge clk);
    check(product == last_exp, "R4 result unaffected", product, last_exp);

    // R8: back-to-back start in the done cycle
    issue(16'hC001, 16'h2345);
    do @(negedge clk); while (!done);
    launch(16'h8765, 16'h8000);
    do @(negedge clk); while (!done);
    launch(16'h0003, 16'hFFFD);
    drain();
    check(product == last_exp, "R8 final chained result", product, last_exp);

    // R1 random sweep
    for (int i = 0; i < 1500; i++) begin
      issue(16'($urandom), 16'($urandom));
    end
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule